// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master on a two-wire management bus. From the system clock it produces the management clock (MDC) and runs the bidirectional data line through three separate signals: a driven value, an output enable and a sampled input. A request handshake carries the operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then serialises one complete frame and reports completion with a one-cycle `done` pulse. For a read, `done` comes with the 16-bit read value and an error flag.

Every frame starts with a run of ones and then the start and opcode pairs and the two address fields. For a write, the master drives the turnaround pair and then the data. For a read, it releases the line and samples the turnaround bit, which the PHY must pull low. If that bit reads high, no PHY answered. The block then clocks a fixed flush sequence with the line released, returns all-ones and raises `err`. Successful reads and all writes end with one extra released clock.

The controller is a single state machine with the states IDLE, PRE (preamble), SOF (start-of-frame), OPC (opcode), PHY, REG, WTA (write turnaround), WDAT (write data), RTA (read turnaround), RDAT (read data), FLUSH, TRAIL (trailing released clock) and DONE. The transitions are:
- IDLE→PRE on `req`.
- PRE→SOF→OPC→PHY→REG, each when its bit count runs out.
- REG→WTA on a write, or REG→RTA on a read.
- WTA→WDAT→TRAIL.
- RTA→RDAT when the turnaround bit reads low, or RTA→FLUSH when it reads high.
- RDAT→TRAIL.
- FLUSH→DONE and TRAIL→DONE.
- DONE→IDLE unconditionally.

A separate phase generator times each bit. Each bit has a low half and a high half. Outgoing bits change only when MDC falls. Incoming bits are sampled at the end of a lengthened high half.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever `busy` is low, `mdc` is low, `mdio_oe` is low, and `done` is low.
- R2: For a driven bit, MDC stays low for HALF_CYC clock cycles and then high for HALF_CYC cycles. `mdio_o` and `mdio_oe` do not change while MDC is high.
- R3: Every frame begins with 32 MDC cycles in which the master drives a 1.
- R4: The start-of-frame pair is 0 then 1. The opcode pair that follows is 1,0 for a read (`op_read`=1) and 0,1 for a write.
- R5: After the opcode, the master drives the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R6: On a write, the master drives the turnaround pair 1 then 0 and the 16 data bits MSB first. It then gives one MDC cycle with `mdio_oe` low, for 65 MDC cycles in total.
- R7: On a read, `mdio_oe` is low from the turnaround bit onward. Each released read bit holds MDC high for SAMPLE_CYC cycles, and `mdio_i` is sampled at the end of that high half.
- R8: When the read turnaround samples 0, the next 16 sampled bits form `rdata` MSB first. One released trailing cycle follows, for 64 MDC cycles in total, and `err` is 0 at `done`.
- R9: When the read turnaround samples 1, the master gives 32 more released MDC cycles (79 in total). `rdata` is then 0xFFFF and `err` is 1 at `done`.
- R10: A `req` that arrives while `busy` is high has no effect. The running frame is unchanged, and no second frame or `done` follows.
- R11: `done` is high for exactly one cycle after the last MDC falling edge of a frame. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a frame; taken only while idle |
| op_read | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write value |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read value, or 0xFFFF on a failed turnaround |
| err | output | 1 | Read turnaround was not driven low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
The bit counter, the state and the phase generator all show up in the MDC edge stream. A wrong state or count moves a field boundary or changes the total MDC cycle count (65, 64 or 79). That appears as a wrong bit at a known edge index within one bit time, or as a missing `done` at the end of the frame. A phase counter fault changes the measured low or high length of the very next bit. A wrong turnaround decision shows up as a released tail of the wrong length, together with a wrong `err` and `rdata` at `done`.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_WTA,
        ST_WDAT,
        ST_RTA,
        ST_RDAT,
        ST_FLUSH,
        ST_TRAIL,
        ST_DONE
    } mdio_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Bit phase generator: low half of HALF_CYC cycles, then a high half of
// HALF_CYC (driven bits) or SAMPLE_CYC (sampled bits). bit_end marks the
// last cycle of the high half; the next edge drops MDC.
module mdio_mdc_gen #(
    parameter int HALF_CYC   = 25,
    parameter int SAMPLE_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_hi,
    output logic mdc,
    output logic bit_end
);
    import mdio_mgmt_pkg::*;

    localparam int LIM_MAX = imax(HALF_CYC, SAMPLE_CYC);
    localparam int CW      = $clog2(LIM_MAX) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          phase_hi;

    always_comb begin
        if (phase_hi && slow_hi) lim = CW'(SAMPLE_CYC - 1);
        else                     lim = CW'(HALF_CYC - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (cnt == lim) begin
            cnt      <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt      <= cnt + CW'(1);
        end
    end

    assign mdc     = phase_hi;
    assign bit_end = phase_hi && (cnt == lim);

    // R2: with no frame running the clock must settle low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_fsm.sv
// Frame sequencer: walks the fields of a management frame one bit at a time.
module mdio_frame_fsm #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              op_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              run,
    output logic              slow_hi,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    import mdio_mgmt_pkg::*;

    localparam int CNT_MAX = imax(imax(PRE_LEN, FLUSH_LEN), imax(DATA_W, ADDR_W));
    localparam int BW      = $clog2(CNT_MAX);

    mdio_state_e       st, st_n;
    logic [BW-1:0]     bcnt, bcnt_n;
    logic              rd_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] wd_q, rdata_q;
    logic              err_q;
    logic              last;
    logic [ADDR_W-1:0] phy_sh, reg_sh;
    logic [DATA_W-1:0] wd_sh;

    assign last   = (bcnt == '0);
    assign phy_sh = phy_q >> bcnt;
    assign reg_sh = reg_q >> bcnt;
    assign wd_sh  = wd_q >> bcnt;

    // next state
    always_comb begin
        st_n   = st;
        bcnt_n = bcnt;
        unique case (st)
            ST_IDLE: if (req) begin
                st_n = ST_PRE; bcnt_n = BW'(PRE_LEN - 1);
            end
            ST_PRE: if (bit_end) begin
                if (last) begin st_n = ST_SOF; bcnt_n = BW'(1); end
                else bcnt_n = bcnt - BW'(1);
            end
            ST_SOF: if (bit_end) begin
                if (last) begin st_n = ST_OPC; bcnt_n = BW'(1); end
                else bcnt_n = bcnt - BW'(1);
            end
            ST_OPC: if (bit_end) begin
                if (last) begin st_n = ST_PHY; bcnt_n = BW'(ADDR_W - 1); end
                else bcnt_n = bcnt - BW'(1);
            end
            ST_PHY: if (bit_end) begin
                if (last) begin st_n = ST_REG; bcnt_n = BW'(ADDR_W - 1); end
                else bcnt_n = bcnt - BW'(1);
            end
            ST_REG: if (bit_end) begin
                if (!last) bcnt_n = bcnt - BW'(1);
                else if (rd_q) begin st_n = ST_RTA; bcnt_n = '0; end
                else begin st_n = ST_WTA; bcnt_n = BW'(1); end
            end
            ST_WTA: if (bit_end) begin
                if (last) begin st_n = ST_WDAT; bcnt_n = BW'(DATA_W - 1); end
                else bcnt_n = bcnt - BW'(1);
            end
            ST_WDAT: if (bit_end) begin
                if (last) st_n = ST_TRAIL;
                else bcnt_n = bcnt - BW'(1);
            end
            ST_RTA: if (bit_end) begin
                if (mdio_i) begin st_n = ST_FLUSH; bcnt_n = BW'(FLUSH_LEN - 1); end
                else begin st_n = ST_RDAT; bcnt_n = BW'(DATA_W - 1); end
            end
            ST_RDAT: if (bit_end) begin
                if (last) st_n = ST_TRAIL;
                else bcnt_n = bcnt - BW'(1);
            end
            ST_FLUSH: if (bit_end) begin
                if (last) st_n = ST_DONE;
                else bcnt_n = bcnt - BW'(1);
            end
            ST_TRAIL: if (bit_end) st_n = ST_DONE;
            ST_DONE:  st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bcnt    <= '0;
            rd_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st   <= st_n;
            bcnt <= bcnt_n;
            if (st == ST_IDLE && req) begin
                rd_q  <= op_read;
                phy_q <= phy_addr;
                reg_q <= reg_addr;
                wd_q  <= wdata;
                err_q <= 1'b0;
            end
            if (st == ST_RDAT && bit_end)
                rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
            if (st == ST_FLUSH && bit_end && last) begin
                rdata_q <= '1;
                err_q   <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (st)
            ST_PRE:  begin mdio_oe = 1'b1; mdio_o = 1'b1;        end
            ST_SOF:  begin mdio_oe = 1'b1; mdio_o = last;        end
            ST_OPC:  begin mdio_oe = 1'b1; mdio_o = rd_q ^ last; end
            ST_PHY:  begin mdio_oe = 1'b1; mdio_o = phy_sh[0];   end
            ST_REG:  begin mdio_oe = 1'b1; mdio_o = reg_sh[0];   end
            ST_WTA:  begin mdio_oe = 1'b1; mdio_o = ~last;       end
            ST_WDAT: begin mdio_oe = 1'b1; mdio_o = wd_sh[0];    end
            default: begin mdio_oe = 1'b0; mdio_o = 1'b0;        end
        endcase
    end

    assign run     = (st != ST_IDLE) && (st != ST_DONE);
    assign slow_hi = (st == ST_RTA) || (st == ST_RDAT) || (st == ST_FLUSH);
    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_DONE);
    assign rdata   = rdata_q;
    assign err     = err_q;

    // R10: a request during a frame must not disturb the captured command
    a_r10_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(phy_q) && $stable(reg_q) && $stable(rd_q) && $stable(wd_q)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_CYC   = 25,
    parameter int SAMPLE_CYC = 35,
    parameter int PRE_LEN    = 32,
    parameter int FLUSH_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        op_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    logic run, slow_hi, bit_end;

    mdio_mdc_gen #(
        .HALF_CYC   (HALF_CYC),
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .slow_hi (slow_hi),
        .mdc     (mdc),
        .bit_end (bit_end)
    );

    mdio_frame_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PRE_LEN   (PRE_LEN),
        .FLUSH_LEN (FLUSH_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .op_read  (op_read),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .bit_end  (bit_end),
        .mdio_i   (mdio_i),
        .run      (run),
        .slow_hi  (slow_hi),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .err      (err)
    );

    // R2: line value and direction hold while MDC is high
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R1: idle means clock low and line released
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && !done));

    // R11: completion is a single-cycle pulse followed by idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: an error completion always reports all-ones
    a_r9_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rdata == 16'hFFFF));

endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
    localparam int H = 3;
    localparam int S = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        op_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    mdio_master #(.HALF_CYC(H), .SAMPLE_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .op_read(op_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .err(err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: pull-up when nobody drives
    logic        phy_on = 1'b0;
    logic [15:0] phy_data = '0;
    logic        drv_en = 1'b0;
    logic        drv_val = 1'b1;
    assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_val : 1'b1);

    int n_total = 0;
    int n_fail  = 0;

    // edge monitor
    logic bit_o  [0:127];
    logic bit_oe [0:127];
    int   hi_len [0:127];
    int   lo_len [0:127];
    int   nb = 0;
    int   hi_cnt = 0;
    int   lo_cnt = 0;
    int   stab_err = 0;
    int   done_cnt = 0;
    logic mdc_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !mdc_prev) begin
                if (nb < 128) begin
                    bit_o[nb]  = mdio_o;
                    bit_oe[nb] = mdio_oe;
                    lo_len[nb] = lo_cnt;
                end
                if (phy_on) begin
                    if (nb == 46) begin drv_en = 1'b1; drv_val = 1'b0; end
                    else if (nb >= 47 && nb <= 62) begin drv_en = 1'b1; drv_val = phy_data[62-nb]; end
                    else drv_en = 1'b0;
                end
                nb = nb + 1;
                hi_cnt = 1;
            end else if (mdc) begin
                hi_cnt = hi_cnt + 1;
                if (nb > 0 && nb <= 128 && (mdio_o !== bit_o[nb-1] || mdio_oe !== bit_oe[nb-1]))
                    stab_err = stab_err + 1;
            end
            if (!mdc && mdc_prev) begin
                if (nb > 0 && nb <= 128) hi_len[nb-1] = hi_cnt;
                lo_cnt = 1;
            end else if (!mdc) begin
                lo_cnt = lo_cnt + 1;
            end
            if (done) done_cnt = done_cnt + 1;
            mdc_prev = mdc;
        end
    end

    // expected frame
    logic exp_o  [0:127];
    logic exp_oe [0:127];
    int   exp_n;

    task automatic put(input logic v, input logic oe);
        exp_o[exp_n]  = v;
        exp_oe[exp_n] = oe;
        exp_n = exp_n + 1;
    endtask

    task automatic build_exp(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic phy_present);
        exp_n = 0;
        for (int i = 0; i < 32; i++) put(1'b1, 1'b1);
        put(1'b0, 1'b1); put(1'b1, 1'b1);
        put(rd, 1'b1);   put(!rd, 1'b1);
        for (int i = 4; i >= 0; i--) put(pa[i], 1'b1);
        for (int i = 4; i >= 0; i--) put(ra[i], 1'b1);
        if (!rd) begin
            put(1'b1, 1'b1); put(1'b0, 1'b1);
            for (int i = 15; i >= 0; i--) put(wd[i], 1'b1);
            put(1'b0, 1'b0);
        end else if (phy_present) begin
            for (int i = 0; i < 18; i++) put(1'b0, 1'b0);
        end else begin
            for (int i = 0; i < 33; i++) put(1'b0, 1'b0);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total = n_total + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int mism = 0;
        for (int k = lo; k <= hi; k++)
            if (bit_oe[k] !== exp_oe[k] || (exp_oe[k] && bit_o[k] !== exp_o[k])) mism++;
        chk(mism == 0, tag, mism, 0);
    endtask

    task automatic pulse_req(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd);
        @(negedge clk);
        op_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic start_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                               input logic [15:0] wd);
        @(negedge clk);
        nb = 0; done_cnt = 0; stab_err = 0; drv_en = 1'b0;
        pulse_req(rd, pa, ra, wd);
    endtask

    task automatic wait_done();
        bit seen = 0;
        int n = 0;
        while (!seen && n < 5000) begin
            @(negedge clk);
            if (done) seen = 1;
            n++;
        end
        chk(seen, "R11 done pulse seen", int'(seen), 1);
        @(negedge clk);
        chk(!done && !busy, "R11 done one cycle then idle", int'({done, busy}), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !mdc && !mdio_oe, "R1 reset quiet",
            int'({busy, done, mdc, mdio_oe}), 0);
    endtask

    task automatic t_write();
        phy_on = 1'b0;
        build_exp(1'b0, 5'h11, 5'h05, 16'hB38E, 1'b0);
        start_frame(1'b0, 5'h11, 5'h05, 16'hB38E);
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy during frame", int'(busy), 1);
        wait_done();
        chk(nb == 65, "R6 write clock count", nb, 65);
        cmp_range(0, 31, "R3 preamble ones");
        cmp_range(32, 35, "R4 start and write opcode");
        cmp_range(36, 45, "R5 address fields");
        cmp_range(46, 64, "R6 turnaround data trail");
        chk(lo_len[10] == H && hi_len[10] == H, "R2 driven bit low/high length",
            lo_len[10] * 100 + hi_len[10], H * 100 + H);
        chk(stab_err == 0, "R2 stable while MDC high", stab_err, 0);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);
        chk(!busy && !mdc && !mdio_oe, "R1 idle after frame", int'({busy, mdc, mdio_oe}), 0);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        phy_on = 1'b1; phy_data = d;
        build_exp(1'b1, pa, ra, 16'h0, 1'b1);
        start_frame(1'b1, pa, ra, 16'h0);
        wait_done();
        chk(nb == 64, "R8 read clock count", nb, 64);
        cmp_range(32, 35, "R4 start and read opcode");
        cmp_range(36, 45, "R5 address fields read");
        cmp_range(46, 63, "R7 released from turnaround");
        chk(hi_len[50] == S, "R7 sample high length", hi_len[50], S);
        chk(hi_len[40] == H, "R2 driven high length on read", hi_len[40], H);
        chk(rdata == d, "R8 read data", int'(rdata), int'(d));
        chk(err == 1'b0, "R8 no error", int'(err), 0);
        chk(stab_err == 0, "R2 stable while MDC high read", stab_err, 0);
        phy_on = 1'b0; drv_en = 1'b0;
    endtask

    task automatic t_absent();
        phy_on = 1'b0;
        build_exp(1'b1, 5'h03, 5'h02, 16'h0, 1'b0);
        start_frame(1'b1, 5'h03, 5'h02, 16'h0);
        wait_done();
        chk(nb == 79, "R9 flush clock count", nb, 79);
        cmp_range(46, 78, "R9 released flush");
        chk(rdata == 16'hFFFF, "R9 all-ones data", int'(rdata), 16'hFFFF);
        chk(err == 1'b1, "R9 error flag", int'(err), 1);
    endtask

    task automatic t_ignore();
        phy_on = 1'b0;
        build_exp(1'b0, 5'h0C, 5'h13, 16'h5A5A, 1'b0);
        start_frame(1'b0, 5'h0C, 5'h13, 16'h5A5A);
        repeat (150) @(negedge clk);
        pulse_req(1'b1, 5'h1F, 5'h00, 16'hFFFF);
        wait_done();
        chk(nb == 65, "R10 frame length kept", nb, 65);
        cmp_range(0, 64, "R10 frame bits unchanged");
        repeat (300) @(negedge clk);
        chk(!busy && done_cnt == 1 && nb == 65, "R10 no second frame",
            done_cnt * 1000 + nb, 1065);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read(5'h0A, 5'h1F, 16'hA5C3);
        t_absent();
        t_read(5'h15, 5'h01, 16'h0001);
        t_ignore();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total = n_total + 1;
        n_fail  = n_fail + 1;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule